// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block holds the digital side of an 8-bit successive-approximation analog-to-digital converter with eight multiplexed inputs. A single-cycle start request, taken while the block is idle, captures a channel number and a clock-rate bit. The block then drives a channel-select bus to the external input selector and a trial-code bus to the external DAC. It reads back one comparator bit that says whether the sampled input lies below the DAC level.

Each conversion lasts a fixed 27 converter-clock periods. The first 6 periods are a sampling window. Eight bit trials follow, from the most significant bit to the least significant bit. The remaining periods are idle padding. The converter clock runs at the system clock rate, or at half that rate, as chosen at start. When the conversion ends, the code is stored, a done flag rises and stays high, and a one-cycle interrupt pulse is issued.

Top module: `sar_seq_top`

## Requirements
- R1: A start_i pulse taken while idle makes busy_o high and done_o low in the next cycle. While busy_o is high, trial_o is zero during the sampling periods and nonzero during the trial periods.
- R2: sel_o carries the channel captured at the accepted start. It is not affected by changes on chan_i during the conversion.
- R3: During the first 6 converter periods of a conversion, trial_o is 0.
- R4: Converter period 6+i tests bit 7-i. trial_o equals the bits already resolved with the bit under test set to 1. The tested bit is kept when cmp_below_i is 0 at the end of the period, and it is cleared when cmp_below_i is 1. Period 6 drives 8'h80, and period 7 drives (bit 7 of the result) | 8'h40.
- R5: With clk_half_i = 0 at start, one converter period is one clock cycle, and done_o rises 27 cycles after the start edge.
- R6: With clk_half_i = 1 at start, one converter period is two clock cycles, and done_o rises 54 cycles after the start edge. Changing clk_half_i during a conversion has no effect.
- R7: result_o is the plain binary code: floor(input/LSB). Inputs below the first transition give 8'h00, and inputs above the last transition give 8'hFF.
- R8: A start_i pulse while busy_o is high is ignored. The timing, channel and result of the running conversion are unchanged.
- R9: done_o stays high, and result_o stays stable, until the next accepted start. irq_o is high for exactly the one cycle in which done_o rises.
- R10: While rst_ni is low, busy_o, done_o, irq_o, result_o, trial_o and sel_o are all 0, even if a conversion was running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request, taken when idle |
| chan_i | input | 3 | Channel number captured at start |
| clk_half_i | input | 1 | 1: converter clock is half the system clock |
| cmp_below_i | input | 1 | Comparator: input below DAC level |
| sel_o | output | 3 | Channel select to input selector |
| trial_o | output | 8 | Trial code to DAC |
| result_o | output | 8 | Last completed conversion code |
| done_o | output | 1 | Result valid, cleared by next start |
| irq_o | output | 1 | One-cycle pulse when a result is stored |
| busy_o | output | 1 | Conversion in progress |

## Verification
The bench builds the block with its default parameters: 8-bit resolution, 8 channels, a 27-period frame and a 6-period sampling window. With these values it can check exact cycle counts for both clock rates, and check the trial pattern period by period. The comparator model works in quarter-LSB steps. This lets inputs fall between codes, below the first transition and above the last one, so that both extreme codes and truncation are exercised.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_TRIAL  = 2'd2,
    PH_PAD    = 2'd3
  } sar_phase_e;
endpackage

// File: rtl/sar_tick_gen.sv
module sar_tick_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic half_i,
  output logic tick_o
);
  logic div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= 1'b0;
    else if (!run_i) div_q <= 1'b0;
    else             div_q <= ~div_q;
  end

  // half rate: tick on every second busy cycle
  assign tick_o = run_i && (!half_i || div_q);
endmodule

// File: rtl/sar_timer.sv
module sar_timer
  import sar_pkg::*;
#(
  parameter int unsigned T_TOTAL  = 27,
  parameter int unsigned T_SAMPLE = 6,
  parameter int unsigned RES_BITS = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic       tick_i,
  output logic       busy_o,
  output sar_phase_e phase_o,
  output logic       last_o
);
  localparam int unsigned CNT_W = $clog2(T_TOTAL);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  assign last_o = busy_q && tick_i && (cnt_q == CNT_W'(T_TOTAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (go_i) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (last_o) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (busy_q && tick_i) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    if (!busy_q)                                      phase_o = PH_IDLE;
    else if (cnt_q < CNT_W'(T_SAMPLE))                phase_o = PH_SAMPLE;
    else if (cnt_q < CNT_W'(T_SAMPLE + RES_BITS))     phase_o = PH_TRIAL;
    else                                              phase_o = PH_PAD;
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/sar_reg.sv
module sar_reg #(
  parameter int unsigned RES_BITS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                tick_i,
  input  logic                trial_en_i,
  input  logic                drive_i,
  input  logic                cmp_below_i,
  output logic [RES_BITS-1:0] code_o,
  output logic [RES_BITS-1:0] trial_o
);
  logic [RES_BITS-1:0] code_q;
  logic [RES_BITS-1:0] mask_q;   // one-hot bit under test

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      mask_q <= '0;
    end else if (clear_i) begin
      code_q <= '0;
      mask_q <= {1'b1, {(RES_BITS-1){1'b0}}};
    end else if (tick_i && trial_en_i) begin
      if (!cmp_below_i) code_q <= code_q | mask_q;
      mask_q <= mask_q >> 1;
    end
  end

  assign code_o  = code_q;
  assign trial_o = drive_i ? (code_q | (trial_en_i ? mask_q : '0)) : '0;
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
  import sar_pkg::*;
#(
  parameter int unsigned RES_BITS = 8,
  parameter int unsigned N_CH     = 8,
  parameter int unsigned T_TOTAL  = 27,
  parameter int unsigned T_SAMPLE = 6,
  localparam int unsigned CH_W    = $clog2(N_CH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [CH_W-1:0]     chan_i,
  input  logic                clk_half_i,
  input  logic                cmp_below_i,
  output logic [CH_W-1:0]     sel_o,
  output logic [RES_BITS-1:0] trial_o,
  output logic [RES_BITS-1:0] result_o,
  output logic                done_o,
  output logic                irq_o,
  output logic                busy_o
);
  logic                busy_w, tick_w, last_w, go_w;
  logic                half_q, done_q, irq_q;
  logic [CH_W-1:0]     chan_q;
  logic [RES_BITS-1:0] code_w, result_q;
  logic                sample_w, trial_en_w, drive_w;
  sar_phase_e          phase_w;

  assign go_w       = start_i && !busy_w;
  assign sample_w   = (phase_w == PH_SAMPLE);
  assign trial_en_w = (phase_w == PH_TRIAL);
  assign drive_w    = (phase_w == PH_TRIAL) || (phase_w == PH_PAD);

  sar_tick_gen u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_w),
    .half_i (half_q),
    .tick_o (tick_w)
  );

  sar_timer #(
    .T_TOTAL  (T_TOTAL),
    .T_SAMPLE (T_SAMPLE),
    .RES_BITS (RES_BITS)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (go_w),
    .tick_i  (tick_w),
    .busy_o  (busy_w),
    .phase_o (phase_w),
    .last_o  (last_w)
  );

  sar_reg #(
    .RES_BITS (RES_BITS)
  ) u_sar (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (go_w),
    .tick_i      (tick_w),
    .trial_en_i  (trial_en_w),
    .drive_i     (drive_w),
    .cmp_below_i (cmp_below_i),
    .code_o      (code_w),
    .trial_o     (trial_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_q   <= '0;
      half_q   <= 1'b0;
      result_q <= '0;
      done_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= last_w;
      if (go_w) begin
        chan_q <= chan_i;
        half_q <= clk_half_i;
        done_q <= 1'b0;
      end else if (last_w) begin
        result_q <= code_w;
        done_q   <= 1'b1;
      end
    end
  end

  assign sel_o    = chan_q;
  assign result_o = result_q;
  assign done_o   = done_q;
  assign irq_o    = irq_q;
  assign busy_o   = busy_w;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int unsigned RES_BITS = 8,
  parameter int unsigned CH_W     = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                busy_o,
  input logic                done_o,
  input logic                irq_o,
  input logic                sample_i,
  input logic [CH_W-1:0]     sel_o,
  input logic [RES_BITS-1:0] trial_o,
  input logic [RES_BITS-1:0] result_o
);
  // R2
  sel_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(sel_o));

  // R3
  sample_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && sample_i) |-> (trial_o == '0));

  // R9
  done_on_finish_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($fell(busy_o) && irq_o));

  // R9
  irq_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  // R1
  done_busy_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && busy_o));

  // R9
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> $stable(result_o));
endmodule

bind sar_seq_top sar_seq_chk #(
  .RES_BITS (RES_BITS),
  .CH_W     (CH_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .irq_o    (irq_o),
  .sample_i (sample_w),
  .sel_o    (sel_o),
  .trial_o  (trial_o),
  .result_o (result_o)
);

// File: tb/tb_sar_seq_top.sv
module tb_sar_seq_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [2:0] chan_i = '0;
  logic       clk_half_i = 1'b0;
  logic       cmp_below_i;
  logic [2:0] sel_o;
  logic [7:0] trial_o, result_o;
  logic       done_o, irq_o, busy_o;

  int checks = 0;
  int errors = 0;
  int ain [8];  // analog inputs in quarter-LSB units

  always #4 clk = ~clk;

  // behavioural mux + DAC + comparator
  always_comb cmp_below_i = ain[sel_o] < (int'(trial_o) * 4);

  sar_seq_top dut (
    .clk_i (clk), .rst_ni (rst_ni), .start_i (start_i), .chan_i (chan_i),
    .clk_half_i (clk_half_i), .cmp_below_i (cmp_below_i), .sel_o (sel_o),
    .trial_o (trial_o), .result_o (result_o), .done_o (done_o),
    .irq_o (irq_o), .busy_o (busy_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_code(input int v);
    int c = v / 4;
    return (c > 255) ? 255 : c;
  endfunction

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    // R10
    chk(busy_o == 0 && done_o == 0 && irq_o == 0, "R10 flags", {busy_o, done_o, irq_o}, 0);
    chk(result_o == 0 && trial_o == 0 && sel_o == 0, "R10 data", {result_o, trial_o, 5'(sel_o)}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  // one conversion; optional mid-run channel change and extra start
  task automatic t_conv(input int ch, input bit half, input bit poke);
    int  d = half ? 2 : 1;
    int  n = 0;
    int  ec = exp_code(ain[ch]);
    bit  samp_ok = 1, sel_ok = 1;
    logic [7:0] prev = result_o;
    chan_i = 3'(ch); clk_half_i = half; start_i = 1'b1;
    @(posedge clk); @(negedge clk);
    start_i = 1'b0;
    clk_half_i = ~half;  // R6: ignored mid-run
    // R1
    chk(busy_o == 1 && done_o == 0, "R1 start", {busy_o, done_o}, 2);
    while (!done_o && n < 200) begin
      int p = n / d;
      if (p < 6 && trial_o != 0) samp_ok = 0;
      if (sel_o != 3'(ch)) sel_ok = 0;
      if (n == 6 * d) chk(trial_o == 8'h80, "R4 period6", trial_o, 8'h80);
      if (n == 7 * d) chk(trial_o == ((ec & 8'h80) | 8'h40), "R4 period7", trial_o, (ec & 8'h80) | 8'h40);
      if (n == 3 * d) chk(busy_o == 1 && result_o == prev, "R1 busy hold", result_o, prev);
      if (poke && n == 8) begin chan_i = 3'(ch + 3); start_i = 1'b1; end
      if (poke && n == 9) start_i = 1'b0;
      @(posedge clk); n++; @(negedge clk);
    end
    chk(samp_ok, "R3 sampling trial zero", samp_ok, 1);
    chk(sel_ok, poke ? "R2/R8 sel held" : "R2 sel", sel_ok, 1);
    chk(n == 27 * d, half ? "R6 half-rate length" : "R5 full-rate length", n, 27 * d);
    chk(result_o == 8'(ec), poke ? "R8 result" : "R7 result", result_o, ec);
    chk(irq_o == 1 && busy_o == 0, "R9 irq on done", irq_o, 1);
    @(negedge clk);
    chk(irq_o == 0 && done_o == 1, "R9 irq single", {irq_o, done_o}, 1);
  endtask

  task automatic t_hold();
    logic [7:0] r = result_o;
    repeat (6) @(negedge clk);
    // R9
    chk(done_o == 1 && irq_o == 0 && result_o == r, "R9 done hold", result_o, r);
  endtask

  task automatic t_reset_mid();
    chan_i = 3'd2; start_i = 1'b1;
    @(posedge clk); @(negedge clk);
    start_i = 1'b0;
    repeat (10) @(negedge clk);
    t_reset();
    chk(busy_o == 0 && done_o == 0 && result_o == 0, "R10 after mid reset", result_o, 0);
  endtask

  initial begin
    ain[0] = 1;            // below first transition -> 00
    ain[1] = 5000;         // above full scale -> FF
    ain[2] = 4 * 8'h5A + 2;
    ain[3] = 4 * 8'hA5;
    ain[4] = 4 * 8'h80 - 1;
    ain[5] = 4;
    ain[6] = 4 * 8'hFE + 3;
    ain[7] = 4 * 8'h33;
    t_reset();
    t_conv(0, 0, 0);
    t_conv(1, 0, 0);
    t_hold();
    t_conv(2, 1, 0);
    t_conv(3, 0, 1);
    t_conv(4, 1, 1);
    t_conv(5, 0, 0);
    t_conv(6, 0, 0);
    t_conv(7, 1, 0);
    t_hold();
    t_reset_mid();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule